// File: doc/BRIEF.md
# Variable-Page-Size Address Translation Cache

This block is a small fully associative translation cache for a device-side memory management unit. Each of its entries holds a CAM word (virtual tag, page-size code, valid flag, keep flag) and a RAM word (physical base, byte order, element size, mixed flag). A 32-bit lookup port presents a virtual address; one cycle later the block reports a single hit with the translated physical address, a miss, or a multi-hit fault. Because every entry carries its own page-size code, entries of 4 KB, 64 KB, 1 MB and 16 MB pages can coexist, each compared under its own mask.

Software drives the block through a register-style port. It stages a CAM word, a RAM word and a victim slot, then writes a load strobe. It can invalidate the entries that cover a given virtual address, or invalidate every entry whose keep flag is clear. It can read any entry back through a read index. A command sequencer with the states CMD_IDLE, CMD_LOAD, CMD_FLUSH_ONE and CMD_FLUSH_ALL carries out these commands. A command write accepted in CMD_IDLE moves it to the matching state. Every other state returns to CMD_IDLE after one cycle. Sticky status bits with an enable mask drive the interrupt line, and the faulting virtual address is captured for software.

Top module: `vtlb_top`

## Requirements
- R1: After reset every entry is invalid, status and enable read 0, `irq` and `busy` are 0, `lk_done` is 0, and any lookup misses.
- R2: Page-size code 0 selects 1 MB, code 1 selects 64 KB, code 2 selects 4 KB and code 3 selects 16 MB. The CAM bits [31:12] are compared with the lookup address only above the page boundary: bits 31:24, 31:20, 31:16 or 31:12.
- R3: On a hit, `lk_pa` takes the bits inside the page mask from RAM bits [31:12] and the bits outside the mask from the lookup address. RAM bits 11:0 never reach `lk_pa`.
- R4: An entry takes part in matching only when CAM bit 2 (valid) is 1.
- R5: When two or more valid entries match, the result is `lk_multi` with no hit, and status bit 4 is set.
- R6: When no entry matches, the result is `lk_miss` and status bit 0 is set. On a miss or a multi-hit, the lookup address is latched into the fault-address register (offset 11).
- R7: Writing a virtual address to offset 4 clears the valid bit of every entry that matches it under that entry's own mask. Other entries are left unchanged.
- R8: Writing offset 5 clears the valid bit of every entry whose CAM bit 3 (keep) is 0. Entries with keep set stay valid.
- R9: Status bits (offset 9) are sticky and are cleared by writing 1 to them. A fault arriving in the same cycle as the clear wins.
- R10: `irq` is 1 exactly when some status bit and the same bit of the enable register (offset 10) are both 1.
- R11: The CAM (offset 0) and RAM (offset 1) staging words are written into the slot named by offset 2 one cycle after a write to offset 3. Offsets 7 and 8 read back the CAM and RAM words of the slot named by offset 6, exactly as written except for valid-bit clears.
- R12: An accepted command (offset 3, 4 or 5) raises `busy` for exactly one cycle. A command write while `busy` is 1 is ignored.
- R13: A lookup request sampled at a clock edge gives `lk_done` for one cycle after that edge, with exactly one of `lk_hit`, `lk_miss` and `lk_multi`. Without a request, `lk_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Exactly one entry matched |
| lk_miss | output | 1 | No entry matched |
| lk_multi | output | 1 | Two or more entries matched |
| lk_pa | output | 32 | Translated physical address (valid with `lk_hit`) |
| busy | output | 1 | Command sequencer not in CMD_IDLE |
| irq | output | 1 | Interrupt, OR of enabled status bits |

## Verification
The hardest cases to reach from the ports are a command write arriving while the sequencer is still busy, and a status clear landing in the same cycle as a new fault. The stimulus times both against the clock edge. It issues a load strobe and, in the very next cycle, a flush-all. The loaded slot then survives a later lookup, which shows that the flush was ignored. In a separate step, one clock edge samples a miss lookup and a write-1-to-clear of status bit 0 together. The entry set mixes all four page sizes, a kept entry, an invalid entry, and two overlapping entries of different sizes, so the multi-hit and mask-selective flush paths are reached.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

    localparam int VA_W      = 32;
    localparam int STS_W     = 5;
    localparam int STS_MISS  = 0;
    localparam int STS_MULTI = 4;
    localparam int CAM_VLD   = 2;
    localparam int CAM_KEEP  = 3;

    localparam logic [3:0] RG_CAM   = 4'd0;
    localparam logic [3:0] RG_RAM   = 4'd1;
    localparam logic [3:0] RG_VICT  = 4'd2;
    localparam logic [3:0] RG_LOAD  = 4'd3;
    localparam logic [3:0] RG_FL1   = 4'd4;
    localparam logic [3:0] RG_FLA   = 4'd5;
    localparam logic [3:0] RG_RDIDX = 4'd6;
    localparam logic [3:0] RG_RDCAM = 4'd7;
    localparam logic [3:0] RG_RDRAM = 4'd8;
    localparam logic [3:0] RG_STS   = 4'd9;
    localparam logic [3:0] RG_EN    = 4'd10;
    localparam logic [3:0] RG_FAULT = 4'd11;

    typedef enum logic [1:0] {
        PG_1M  = 2'd0,
        PG_64K = 2'd1,
        PG_4K  = 2'd2,
        PG_16M = 2'd3
    } pg_code_e;

    typedef enum logic [1:0] {
        CMD_IDLE      = 2'd0,
        CMD_LOAD      = 2'd1,
        CMD_FLUSH_ONE = 2'd2,
        CMD_FLUSH_ALL = 2'd3
    } cmd_state_e;

    function automatic logic [VA_W-1:0] page_mask(input logic [1:0] code);
        logic [VA_W-1:0] m;
        unique case (pg_code_e'(code))
            PG_1M:   m = 32'hFFF0_0000;
            PG_64K:  m = 32'hFFFF_0000;
            PG_4K:   m = 32'hFFFF_F000;
            PG_16M:  m = 32'hFF00_0000;
            default: m = 32'hFFFF_F000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vtlb_entry.sv
module vtlb_entry
    import vtlb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [VA_W-1:0] cam_in,
    input  logic [VA_W-1:0] ram_in,
    input  logic            flush_one,
    input  logic [VA_W-1:0] flush_va,
    input  logic            flush_all,
    input  logic [VA_W-1:0] look_va,
    output logic [VA_W-1:0] cam_q,
    output logic [VA_W-1:0] ram_q,
    output logic            look_hit,
    output logic [VA_W-1:0] look_pa
);

    logic [VA_W-1:0] cam_r;
    logic [VA_W-1:0] ram_r;
    logic [VA_W-1:0] mask;
    logic            vld;
    logic            fl_hit;
    logic            drop;

    assign mask     = page_mask(cam_r[1:0]);
    assign vld      = cam_r[CAM_VLD];
    assign fl_hit   = vld && (((flush_va ^ cam_r) & mask) == '0);
    assign look_hit = vld && (((look_va ^ cam_r) & mask) == '0);
    assign look_pa  = (ram_r & mask) | (look_va & ~mask);
    assign drop     = (flush_one && fl_hit) || (flush_all && !cam_r[CAM_KEEP]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cam_r <= '0;
            ram_r <= '0;
        end else if (wr_en) begin
            cam_r <= cam_in;
            ram_r <= ram_in;
        end else if (drop) begin
            cam_r[CAM_VLD] <= 1'b0;
        end
    end

    assign cam_q = cam_r;
    assign ram_q = ram_r;

    // R7
    flush_one_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_one && fl_hit && !wr_en) |=> !cam_r[CAM_VLD]);

    // R8
    keep_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all && cam_r[CAM_KEEP] && vld && !wr_en) |=> cam_r[CAM_VLD]);

endmodule

// File: rtl/vtlb_lookup.sv
module vtlb_lookup
    import vtlb_pkg::*;
#(
    parameter int N_ENT = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req,
    input  logic [N_ENT-1:0]           hit_vec,
    input  logic [N_ENT-1:0][VA_W-1:0] pa_vec,
    output logic                       ev_miss,
    output logic                       ev_multi,
    output logic                       done,
    output logic                       hit,
    output logic                       miss,
    output logic                       multi,
    output logic [VA_W-1:0]            pa
);

    localparam int CNT_W = $clog2(N_ENT + 1);

    logic [CNT_W-1:0] cnt;
    logic [VA_W-1:0]  pa_sel;

    always_comb begin
        cnt    = '0;
        pa_sel = '0;
        for (int i = 0; i < N_ENT; i++) begin
            cnt = cnt + CNT_W'(hit_vec[i]);
            if (hit_vec[i]) pa_sel = pa_sel | pa_vec[i];
        end
    end

    assign ev_miss  = req && (cnt == '0);
    assign ev_multi = req && (cnt > CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done  <= 1'b0;
            hit   <= 1'b0;
            miss  <= 1'b0;
            multi <= 1'b0;
            pa    <= '0;
        end else begin
            done  <= req;
            hit   <= req && (cnt == CNT_W'(1));
            miss  <= ev_miss;
            multi <= ev_multi;
            if (req && cnt == CNT_W'(1)) pa <= pa_sel;
        end
    end

    // R13
    done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> done);

    // R13
    no_req_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !done);

    // R13
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot({hit, miss, multi}));

endmodule

// File: rtl/vtlb_status.sv
module vtlb_status
    import vtlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_miss,
    input  logic             ev_multi,
    input  logic [VA_W-1:0]  ev_va,
    input  logic             reg_wr,
    input  logic [3:0]       reg_addr,
    input  logic [STS_W-1:0] reg_wbits,
    output logic [STS_W-1:0] sts,
    output logic [STS_W-1:0] en,
    output logic [VA_W-1:0]  fault_va,
    output logic             irq
);

    logic [STS_W-1:0] clr;
    logic [STS_W-1:0] set;

    always_comb begin
        clr = (reg_wr && reg_addr == RG_STS) ? reg_wbits : '0;
        set = '0;
        set[STS_MISS]  = ev_miss;
        set[STS_MULTI] = ev_multi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts      <= '0;
            en       <= '0;
            fault_va <= '0;
        end else begin
            sts <= (sts & ~clr) | set;
            if (reg_wr && reg_addr == RG_EN) en <= reg_wbits;
            if (ev_miss || ev_multi) fault_va <= ev_va;
        end
    end

    assign irq = |(sts & en);

    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(sts) & ~$past(clr)) & ~sts) == '0));

    // R5
    multi_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_multi |=> sts[STS_MULTI]);

    // R6
    fault_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_miss || ev_multi) |=> (fault_va == $past(ev_va)));

endmodule

// File: rtl/vtlb_ctrl.sv
module vtlb_ctrl
    import vtlb_pkg::*;
#(
    parameter int N_ENT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [3:0]       reg_addr,
    input  logic [VA_W-1:0]  reg_wdata,
    output logic [VA_W-1:0]  stage_cam,
    output logic [VA_W-1:0]  stage_ram,
    output logic [$clog2(N_ENT)-1:0] victim,
    output logic [$clog2(N_ENT)-1:0] rd_idx,
    output logic [VA_W-1:0]  flush_va,
    output logic             load_go,
    output logic             flush_one_go,
    output logic             flush_all_go,
    output logic             busy
);

    localparam int IDX_W = $clog2(N_ENT);

    cmd_state_e state_q;
    cmd_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_IDLE: begin
                if (reg_wr) begin
                    if (reg_addr == RG_LOAD)     state_d = CMD_LOAD;
                    else if (reg_addr == RG_FL1) state_d = CMD_FLUSH_ONE;
                    else if (reg_addr == RG_FLA) state_d = CMD_FLUSH_ALL;
                end
            end
            CMD_LOAD:      state_d = CMD_IDLE;
            CMD_FLUSH_ONE: state_d = CMD_IDLE;
            CMD_FLUSH_ALL: state_d = CMD_IDLE;
            default:       state_d = CMD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CMD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_cam <= '0;
            stage_ram <= '0;
            victim    <= '0;
            rd_idx    <= '0;
            flush_va  <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                RG_CAM:   stage_cam <= reg_wdata;
                RG_RAM:   stage_ram <= reg_wdata;
                RG_VICT:  victim    <= reg_wdata[IDX_W-1:0];
                RG_RDIDX: rd_idx    <= reg_wdata[IDX_W-1:0];
                RG_FL1:   if (state_q == CMD_IDLE) flush_va <= reg_wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        load_go      = 1'b0;
        flush_one_go = 1'b0;
        flush_all_go = 1'b0;
        unique case (state_q)
            CMD_IDLE:      ;
            CMD_LOAD:      load_go      = 1'b1;
            CMD_FLUSH_ONE: flush_one_go = 1'b1;
            CMD_FLUSH_ALL: flush_all_go = 1'b1;
            default:       ;
        endcase
        busy = (state_q != CMD_IDLE);
    end

    // R12
    busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CMD_IDLE) |=> (state_q == CMD_IDLE));

    // R12
    single_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_go, flush_one_go, flush_all_go}));

endmodule

// File: rtl/vtlb_top.sv
module vtlb_top
    import vtlb_pkg::*;
#(
    parameter int N_ENT = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        lk_req,
    input  logic [31:0] lk_va,
    output logic        lk_done,
    output logic        lk_hit,
    output logic        lk_miss,
    output logic        lk_multi,
    output logic [31:0] lk_pa,
    output logic        busy,
    output logic        irq
);

    localparam int IDX_W = $clog2(N_ENT);

    logic [VA_W-1:0]             stage_cam;
    logic [VA_W-1:0]             stage_ram;
    logic [IDX_W-1:0]            victim;
    logic [IDX_W-1:0]            rd_idx;
    logic [VA_W-1:0]             flush_va;
    logic                        load_go;
    logic                        flush_one_go;
    logic                        flush_all_go;
    logic [N_ENT-1:0][VA_W-1:0]  cam_all;
    logic [N_ENT-1:0][VA_W-1:0]  ram_all;
    logic [N_ENT-1:0][VA_W-1:0]  pa_all;
    logic [N_ENT-1:0]            hit_all;
    logic                        ev_miss;
    logic                        ev_multi;
    logic [STS_W-1:0]            sts;
    logic [STS_W-1:0]            en;
    logic [VA_W-1:0]             fault_va;

    vtlb_ctrl #(.N_ENT(N_ENT)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .stage_cam    (stage_cam),
        .stage_ram    (stage_ram),
        .victim       (victim),
        .rd_idx       (rd_idx),
        .flush_va     (flush_va),
        .load_go      (load_go),
        .flush_one_go (flush_one_go),
        .flush_all_go (flush_all_go),
        .busy         (busy)
    );

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        vtlb_entry u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (load_go && (victim == IDX_W'(g))),
            .cam_in    (stage_cam),
            .ram_in    (stage_ram),
            .flush_one (flush_one_go),
            .flush_va  (flush_va),
            .flush_all (flush_all_go),
            .look_va   (lk_va),
            .cam_q     (cam_all[g]),
            .ram_q     (ram_all[g]),
            .look_hit  (hit_all[g]),
            .look_pa   (pa_all[g])
        );
    end

    vtlb_lookup #(.N_ENT(N_ENT)) u_look (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (lk_req),
        .hit_vec  (hit_all),
        .pa_vec   (pa_all),
        .ev_miss  (ev_miss),
        .ev_multi (ev_multi),
        .done     (lk_done),
        .hit      (lk_hit),
        .miss     (lk_miss),
        .multi    (lk_multi),
        .pa       (lk_pa)
    );

    vtlb_status u_sts (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_miss   (ev_miss),
        .ev_multi  (ev_multi),
        .ev_va     (lk_va),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wbits (reg_wdata[STS_W-1:0]),
        .sts       (sts),
        .en        (en),
        .fault_va  (fault_va),
        .irq       (irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RG_CAM:   reg_rdata = stage_cam;
            RG_RAM:   reg_rdata = stage_ram;
            RG_VICT:  reg_rdata[IDX_W-1:0] = victim;
            RG_RDIDX: reg_rdata[IDX_W-1:0] = rd_idx;
            RG_RDCAM: reg_rdata = cam_all[rd_idx];
            RG_RDRAM: reg_rdata = ram_all[rd_idx];
            RG_STS:   reg_rdata[STS_W-1:0] = sts;
            RG_EN:    reg_rdata[STS_W-1:0] = en;
            RG_FAULT: reg_rdata = fault_va;
            default:  reg_rdata = '0;
        endcase
    end

    // R10
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (sts != '0) && (en != '0));

    // R4
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && (hit_all != '0) |=> !lk_miss);

endmodule

// File: tb/vtlb_top_test.sv
module vtlb_top_test;

    localparam logic [3:0] A_CAM = 4'd0, A_RAM = 4'd1, A_VICT = 4'd2, A_LOAD = 4'd3;
    localparam logic [3:0] A_FL1 = 4'd4, A_FLA = 4'd5, A_RDIDX = 4'd6, A_RDCAM = 4'd7;
    localparam logic [3:0] A_RDRAM = 4'd8, A_STS = 4'd9, A_EN = 4'd10, A_FAULT = 4'd11;

    typedef struct packed {
        logic [31:0] va;
        logic [1:0]  kind;  // 0 hit, 1 miss, 2 multi
        logic [31:0] pa;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h12AB_CDEF, 2'd0, 32'h80AB_CDEF},
        '{32'h345F_FFFF, 2'd0, 32'h901F_FFFF},
        '{32'h5678_ABCD, 2'd0, 32'hA002_ABCD},
        '{32'h9ABC_D123, 2'd0, 32'hB000_3123},
        '{32'h9ABC_E123, 2'd1, 32'h0},
        '{32'h7771_2345, 2'd1, 32'h0},
        '{32'h1234_5678, 2'd2, 32'h0},
        '{32'h5679_ABCD, 2'd1, 32'h0},
        '{32'h3460_0000, 2'd1, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_req = 1'b0;
    logic [31:0] lk_va = '0;
    logic        lk_done, lk_hit, lk_miss, lk_multi, busy, irq;
    logic [31:0] lk_pa;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    vtlb_top uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_req(lk_req), .lk_va(lk_va),
        .lk_done(lk_done), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_multi(lk_multi),
        .lk_pa(lk_pa), .busy(busy), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic cmd(input logic [3:0] a, input logic [31:0] d);
        wr(a, d);
        @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic load(input int idx, input logic [31:0] cam, input logic [31:0] ram);
        wr(A_CAM, cam);
        wr(A_RAM, ram);
        wr(A_VICT, 32'(idx));
        cmd(A_LOAD, 32'h0);
    endtask

    // result packed as {done,hit,miss,multi} and pa
    task automatic look(input logic [31:0] va, output logic [3:0] fl, output logic [31:0] pa);
        @(negedge clk);
        lk_req = 1'b1; lk_va = va;
        @(negedge clk);
        fl = {lk_done, lk_hit, lk_miss, lk_multi};
        pa = lk_pa;
        lk_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [3:0]  fl;
        logic [31:0] pa;
        logic [31:0] d;
        logic [3:0]  exp_fl;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(busy == 1'b0 && irq == 1'b0 && lk_done == 1'b0, "R1", {29'h0, busy, irq, lk_done}, 32'h0);
        rd(A_STS, d);
        check(d == 32'h0, "R1", d, 32'h0);
        rd(A_EN, d);
        check(d == 32'h0, "R1", d, 32'h0);
        look(32'h0000_0000, fl, pa);
        check(fl == 4'b1010, "R1", {28'h0, fl}, 32'hA);
        // R13: done drops without request
        @(negedge clk);
        check(lk_done == 1'b0, "R13", {31'h0, lk_done}, 32'h0);

        // R11: load entries of every page size
        load(0, 32'h1200_0007, 32'h8000_0200);   // 16 MB
        load(1, 32'h3450_0004, 32'h9010_0000);   // 1 MB
        load(2, 32'h5678_0005, 32'hA002_0000);   // 64 KB
        load(3, 32'h9ABC_D00E, 32'hB000_31C0);   // 4 KB, keep
        load(4, 32'h7770_0000, 32'hC000_0000);   // invalid
        load(5, 32'h1234_5006, 32'hD000_0000);   // 4 KB overlapping slot 0

        // R2 R3 R4 R5 R6 R13: vector table
        for (int i = 0; i < NV; i++) begin
            look(VECS[i].va, fl, pa);
            exp_fl = (VECS[i].kind == 2'd0) ? 4'b1100 :
                     (VECS[i].kind == 2'd1) ? 4'b1010 : 4'b1001;
            check(fl == exp_fl, "R2/R4/R5/R6/R13 outcome", {28'h0, fl}, {28'h0, exp_fl});
            if (VECS[i].kind == 2'd0)
                check(pa == VECS[i].pa, "R2/R3 address", pa, VECS[i].pa);
        end

        // R5 R6: sticky status and fault address
        rd(A_STS, d);
        check(d == 32'h11, "R5 R6 status", d, 32'h11);
        rd(A_FAULT, d);
        check(d == 32'h3460_0000, "R6 fault address", d, 32'h3460_0000);
        check(irq == 1'b0, "R10 masked", {31'h0, irq}, 32'h0);

        // R10
        wr(A_EN, 32'h10);
        @(negedge clk);
        check(irq == 1'b1, "R10 enabled", {31'h0, irq}, 32'h1);
        // R9: write-one-to-clear
        wr(A_STS, 32'h10);
        rd(A_STS, d);
        check(d == 32'h01, "R9 clear", d, 32'h01);
        check(irq == 1'b0, "R10 after clear", {31'h0, irq}, 32'h0);
        wr(A_STS, 32'h1F);
        rd(A_STS, d);
        check(d == 32'h0, "R9 clear all", d, 32'h0);
        // R9: fault and clear in the same cycle
        @(negedge clk);
        lk_req = 1'b1; lk_va = 32'hEEEE_0000;
        reg_wr = 1'b1; reg_addr = A_STS; reg_wdata = 32'h1;
        @(negedge clk);
        lk_req = 1'b0; reg_wr = 1'b0;
        rd(A_STS, d);
        check(d == 32'h01, "R9 set wins", d, 32'h01);

        // R11: readback
        wr(A_RDIDX, 32'd3);
        rd(A_RDCAM, d);
        check(d == 32'h9ABC_D00E, "R11 cam", d, 32'h9ABC_D00E);
        rd(A_RDRAM, d);
        check(d == 32'hB000_31C0, "R11 ram", d, 32'hB000_31C0);

        // R7: flush by address spares the 4 KB overlap
        cmd(A_FL1, 32'h1200_0000);
        wr(A_RDIDX, 32'd0);
        rd(A_RDCAM, d);
        check(d == 32'h1200_0003, "R7 cleared", d, 32'h1200_0003);
        look(32'h1234_5678, fl, pa);
        check(fl == 4'b1100 && pa == 32'hD000_0678, "R7 survivor", pa, 32'hD000_0678);

        // R8: flush-all keeps the kept entry
        cmd(A_FLA, 32'h0);
        look(32'h9ABC_D123, fl, pa);
        check(fl == 4'b1100 && pa == 32'hB000_3123, "R8 keep", pa, 32'hB000_3123);
        look(32'h345F_FFFF, fl, pa);
        check(fl == 4'b1010, "R8 dropped", {28'h0, fl}, 32'hA);
        wr(A_RDIDX, 32'd1);
        rd(A_RDCAM, d);
        check(d == 32'h3450_0000, "R8 readback", d, 32'h3450_0000);

        // R12: command while busy is ignored
        wr(A_CAM, 32'h4000_0007);
        wr(A_RAM, 32'h5000_0000);
        wr(A_VICT, 32'd6);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_LOAD; reg_wdata = 32'h0;
        @(negedge clk);
        check(busy == 1'b1, "R12 busy", {31'h0, busy}, 32'h1);
        reg_addr = A_FLA;
        @(negedge clk);
        reg_wr = 1'b0;
        check(busy == 1'b0, "R12 one cycle", {31'h0, busy}, 32'h0);
        look(32'h4000_1234, fl, pa);
        check(fl == 4'b1100 && pa == 32'h5000_1234, "R12 flush ignored", pa, 32'h5000_1234);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule